// File: doc/BRIEF.md
# External/Status Interrupt Latch Controller

This block turns level changes on a serial channel's modem and status lines into one pending interrupt. The lines are carrier detect, clear to send, sync/hunt, break/abort and transmit underrun. Each line passes through a two-flop synchronizer. While the status latches are open, the read port follows the synchronized levels. When a line whose enable bit is set changes level, and the ext/status interrupt enable is also set, the latches close on the next clock edge and the ext/status pending bit is set. From then on the read port holds the levels it captured. It stays frozen until software issues the reset ext/status command, which clears the pending bit and reopens the latches.

A zero-count pulse from the baud-rate counter is never latched. It appears on the read port for a fixed two cycles. If its own enable bit is set, it raises the ext/status interrupt, but only when no ext/status interrupt is already pending. When an interrupt leaves the captured levels unchanged, the zero-count event was its cause.

A separate transmit pending bit is set when the transmit buffer becomes empty or when the closing flag after the CRC is loaded. The interrupt request is the OR of both pending bits, gated by a master enable. With the master enable cleared, software can still poll the pending bits.

Top module: `esi_ctrl`

## Requirements
- R1: After the synchronous active-high reset, both pending bits and the interrupt request are 0, the latches are open, and the zero-count bit of the read port is 0.
- R2: With the latches open, ext_ie set and the line's enable bit set, a level change on a status line that arrives after clock edge k sets ext_pend at edge k+3 (two synchronizer flops plus the latch). From that edge the read port shows the new level.
- R3: While ext_pend is 1 and no reset command is given, the latched status bits of the read port hold their value whatever the lines do.
- R4: A one-cycle rst_ext_cmd clears ext_pend at the next edge. At that same edge the latches load the current synchronized levels and reopen.
- R5: A change on a line whose enable bit is 0, any change while ext_ie is 0, or a zero-count pulse with src_en[5] at 0 leaves ext_pend at 0. While the latches are open, the read port still follows the lines.
- R6: A one-cycle zc_pulse makes stat_rd[5] read 1 for exactly the two cycles after the edge that samples it, and 0 after that.
- R7: A zc_pulse with src_en[5] and ext_ie set, sampled while ext_pend is 0, sets ext_pend at the next edge and closes the latches without altering the latched levels.
- R8: A zc_pulse sampled while ext_pend is 1 changes neither ext_pend nor the latched levels. A single reset command then leaves ext_pend at 0.
- R9: With tx_ie set, a rising edge of tx_empty or a one-cycle tx_eom pulse sets tx_pend at the next edge. rst_tx_cmd clears it, and a set in the same cycle wins. A tx_empty level that stays high does not set it again. With tx_ie at 0, nothing sets it.
- R10: irq is 1 exactly when mie is 1 and a pending bit is set. With mie at 0, ext_pend and tx_pend still read their true values.
- R11: The read port and src_en share one bit layout: bit 0 carrier detect, bit 1 clear to send, bit 2 sync/hunt, bit 3 break/abort, bit 4 transmit underrun, bit 5 zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_in | input | 1 | Carrier detect line (asynchronous) |
| cts_in | input | 1 | Clear to send line (asynchronous) |
| hunt_in | input | 1 | Sync/hunt status line (asynchronous) |
| brk_in | input | 1 | Break/abort status line (asynchronous) |
| txund_in | input | 1 | Transmit underrun status line (asynchronous) |
| zc_pulse | input | 1 | One-cycle zero-count pulse from the baud counter |
| src_en | input | 6 | Per-source enable bits, layout per R11 |
| ext_ie | input | 1 | Ext/status interrupt enable |
| mie | input | 1 | Master interrupt enable |
| rst_ext_cmd | input | 1 | One-cycle reset ext/status command |
| tx_empty | input | 1 | Transmit buffer empty level |
| tx_eom | input | 1 | One-cycle pulse: closing flag after CRC loaded |
| tx_ie | input | 1 | Transmit interrupt enable |
| rst_tx_cmd | input | 1 | One-cycle clear of the transmit pending bit |
| stat_rd | output | 6 | Status read port, layout per R11 |
| ext_pend | output | 1 | Ext/status interrupt pending |
| tx_pend | output | 1 | Transmit interrupt pending |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that zc_pulse, tx_eom and both command strobes come from synchronous logic and last one cycle. They also assume that reset is held for at least one edge before any check counts, and that a status line holds its new level long enough to pass both synchronizer flops. The stimulus keeps every status level steady for at least four cycles. It raises each strobe for exactly one cycle, after a rising clock edge, and starts with reset held for three cycles, so every change is seen once and at a known edge.

// File: rtl/esi_pkg.sv
package esi_pkg;
    localparam int unsigned NUM_LINES   = 5;
    localparam int unsigned NUM_SRC     = NUM_LINES + 1;
    localparam int unsigned IDX_CARRIER = 0;
    localparam int unsigned IDX_CTS     = 1;
    localparam int unsigned IDX_HUNT    = 2;
    localparam int unsigned IDX_BRK     = 3;
    localparam int unsigned IDX_TXUND   = 4;
    localparam int unsigned IDX_ZC      = 5;

    typedef struct packed {
        logic [NUM_LINES-1:0] lvl;   // latched line levels
        logic                 pend;  // ext/status pending, latches closed
    } ext_state_t;

    typedef struct packed {
        logic prev;                  // tx_empty seen last cycle
        logic pend;                  // transmit pending
    } tx_state_t;
endpackage

// File: rtl/esi_sync.sv
module esi_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/esi_zc_stretch.sv
module esi_zc_stretch #(
    parameter int unsigned HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic zc_pulse,
    output logic zc_vis
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (zc_pulse) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zc_vis = (cnt_q != '0);

    // zero count becomes visible right after the sampling edge
    assert_zc_show_R6: assert property (@(posedge clk) disable iff (rst)
        zc_pulse |=> zc_vis);
endmodule

// File: rtl/esi_ext_latch.sv
module esi_ext_latch
    import esi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lvl,
    input  logic [NUM_LINES-1:0] line_en,
    input  logic                 zc_pulse,
    input  logic                 zc_en,
    input  logic                 ext_ie,
    input  logic                 rst_cmd,
    output logic [NUM_LINES-1:0] lat_lvl,
    output logic                 pend
);
    ext_state_t st_d, st_q;
    logic       hit_line, hit_zc;

    always_comb begin
        st_d     = st_q;
        hit_line = ext_ie && (((lvl ^ st_q.lvl) & line_en) != '0);
        hit_zc   = ext_ie && zc_en && zc_pulse;
        if (rst_cmd) begin
            st_d.lvl  = lvl;
            st_d.pend = 1'b0;
        end else if (!st_q.pend) begin
            st_d.lvl = lvl;
            if (hit_line || hit_zc) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lat_lvl = st_q.lvl;
    assign pend    = st_q.pend;

    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && !rst_cmd) |=> $stable(st_q.lvl));

    assert_cmd_clear_R4: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> !st_q.pend);

    assert_ie_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!st_q.pend && !ext_ie) |=> !st_q.pend);

    assert_zc_held_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && zc_pulse && !rst_cmd) |=> st_q.pend);
endmodule

// File: rtl/esi_tx_pend.sv
module esi_tx_pend
    import esi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic tx_eom,
    input  logic tx_ie,
    input  logic rst_tx_cmd,
    output logic pend
);
    tx_state_t st_d, st_q;
    logic      set_ev;

    always_comb begin
        st_d      = st_q;
        set_ev    = tx_ie && ((tx_empty && !st_q.prev) || tx_eom);
        st_d.prev = tx_empty;
        if (set_ev)          st_d.pend = 1'b1;
        else if (rst_tx_cmd) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{prev: 1'b1, pend: 1'b0};
        else     st_q <= st_d;
    end

    assign pend = st_q.pend;

    assert_eom_set_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_ie && tx_eom) |=> st_q.pend);
endmodule

// File: rtl/esi_ctrl.sv
module esi_ctrl
    import esi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ZC_HOLD     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               carrier_in,
    input  logic               cts_in,
    input  logic               hunt_in,
    input  logic               brk_in,
    input  logic               txund_in,
    input  logic               zc_pulse,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               ext_ie,
    input  logic               mie,
    input  logic               rst_ext_cmd,
    input  logic               tx_empty,
    input  logic               tx_eom,
    input  logic               tx_ie,
    input  logic               rst_tx_cmd,
    output logic [NUM_SRC-1:0] stat_rd,
    output logic               ext_pend,
    output logic               tx_pend,
    output logic               irq
);
    logic [NUM_LINES-1:0] raw_lines, sync_lines, lat_lines;
    logic                 zc_vis;

    always_comb begin
        raw_lines              = '0;
        raw_lines[IDX_CARRIER] = carrier_in;
        raw_lines[IDX_CTS]     = cts_in;
        raw_lines[IDX_HUNT]    = hunt_in;
        raw_lines[IDX_BRK]     = brk_in;
        raw_lines[IDX_TXUND]   = txund_in;
    end

    esi_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    esi_zc_stretch #(.HOLD(ZC_HOLD)) u_zc (
        .clk      (clk),
        .rst      (rst),
        .zc_pulse (zc_pulse),
        .zc_vis   (zc_vis)
    );

    esi_ext_latch u_ext (
        .clk      (clk),
        .rst      (rst),
        .lvl      (sync_lines),
        .line_en  (src_en[NUM_LINES-1:0]),
        .zc_pulse (zc_pulse),
        .zc_en    (src_en[IDX_ZC]),
        .ext_ie   (ext_ie),
        .rst_cmd  (rst_ext_cmd),
        .lat_lvl  (lat_lines),
        .pend     (ext_pend)
    );

    esi_tx_pend u_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_empty   (tx_empty),
        .tx_eom     (tx_eom),
        .tx_ie      (tx_ie),
        .rst_tx_cmd (rst_tx_cmd),
        .pend       (tx_pend)
    );

    always_comb begin
        stat_rd                  = '0;
        stat_rd[NUM_LINES-1:0]   = lat_lines;
        stat_rd[IDX_ZC]          = zc_vis;
    end

    assign irq = mie && (ext_pend || tx_pend);
endmodule

// File: tb/tb_esi_ctrl.sv
`timescale 1ns/1ps
module tb_esi_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] lines = '0;
    logic       zc_pulse = 1'b0;
    logic [5:0] src_en = '0;
    logic       ext_ie = 1'b0, mie = 1'b0, rst_ext_cmd = 1'b0;
    logic       tx_empty = 1'b0, tx_eom = 1'b0, tx_ie = 1'b0, rst_tx_cmd = 1'b0;
    logic [5:0] stat_rd;
    logic       ext_pend, tx_pend, irq;

    always #4 clk = ~clk;

    esi_ctrl dut (
        .clk(clk), .rst(rst),
        .carrier_in(lines[0]), .cts_in(lines[1]), .hunt_in(lines[2]),
        .brk_in(lines[3]), .txund_in(lines[4]),
        .zc_pulse(zc_pulse), .src_en(src_en), .ext_ie(ext_ie), .mie(mie),
        .rst_ext_cmd(rst_ext_cmd), .tx_empty(tx_empty), .tx_eom(tx_eom),
        .tx_ie(tx_ie), .rst_tx_cmd(rst_tx_cmd),
        .stat_rd(stat_rd), .ext_pend(ext_pend), .tx_pend(tx_pend), .irq(irq)
    );

    typedef struct {
        int         due;
        string      tag;
        logic [5:0] st;
        logic       e, t, i;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // driver side: queue an expectation d cycles ahead
    task automatic chk(input int d, input string tag, input logic [5:0] st,
                       input logic e, input logic t, input logic i);
        exp_t x;
        x.due = cyc + d; x.tag = tag; x.st = st; x.e = e; x.t = t; x.i = i;
        exp_q.push_back(x);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: compare at the falling edge of the due cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t x;
            x = exp_q.pop_front();
            checks++;
            if (x.due < cyc) begin
                errors++;
                $display("FAIL %s missed at cycle %0d: actual none expected due %0d", x.tag, cyc, x.due);
            end else if (stat_rd !== x.st || ext_pend !== x.e || tx_pend !== x.t || irq !== x.i) begin
                errors++;
                $display("FAIL %s cycle %0d: actual stat=%h ext=%b tx=%b irq=%b expected stat=%h ext=%b tx=%b irq=%b",
                         x.tag, cyc, stat_rd, ext_pend, tx_pend, irq, x.st, x.e, x.t, x.i);
            end
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        chk(0, "R1", 6'h00, 0, 0, 0);
        tick(1);
        src_en = 6'h3F; ext_ie = 1'b1; mie = 1'b1; tx_ie = 1'b1;

        // R2: carrier rises, pending after three edges
        lines = 5'b00001;
        chk(2, "R2", 6'h00, 0, 0, 0);
        chk(3, "R2", 6'h01, 1, 0, 1);
        tick(4);
        // R3: carrier falls while closed, read port frozen
        lines = 5'b00000;
        tick(4);
        chk(0, "R3", 6'h01, 1, 0, 1);
        tick(1);
        // R4: reset command reopens, shows current level
        rst_ext_cmd = 1'b1;
        chk(1, "R4", 6'h00, 0, 0, 0);
        tick(1);
        rst_ext_cmd = 1'b0;
        tick(1);

        // R5: disabled line tracks but does not interrupt
        src_en = 6'h3D;
        lines = 5'b00010;
        chk(3, "R5", 6'h02, 0, 0, 0);
        tick(4);
        // R5: ext_ie off
        ext_ie = 1'b0;
        lines = 5'b01010;
        chk(3, "R5", 6'h0A, 0, 0, 0);
        tick(4);
        ext_ie = 1'b1; src_en = 6'h3F;
        tick(1);
        chk(0, "R5", 6'h0A, 0, 0, 0);
        tick(1);

        // R11: underrun is bit 4
        lines = 5'b11010;
        chk(3, "R11", 6'h1A, 1, 0, 1);
        tick(4);
        rst_ext_cmd = 1'b1;
        chk(1, "R4", 6'h1A, 0, 0, 0);
        tick(1);
        rst_ext_cmd = 1'b0;
        tick(1);

        // R7 and R6: zero count raises pending, visible two cycles
        zc_pulse = 1'b1;
        chk(1, "R7", 6'h3A, 1, 0, 1);
        chk(2, "R6", 6'h3A, 1, 0, 1);
        chk(3, "R6", 6'h1A, 1, 0, 1);
        tick(1);
        zc_pulse = 1'b0;
        tick(3);
        // R8: zero count while pending is ignored
        zc_pulse = 1'b1;
        chk(1, "R8", 6'h3A, 1, 0, 1);
        tick(1);
        zc_pulse = 1'b0;
        tick(3);
        rst_ext_cmd = 1'b1;
        chk(1, "R8", 6'h1A, 0, 0, 0);
        tick(1);
        rst_ext_cmd = 1'b0;
        tick(2);
        chk(0, "R8", 6'h1A, 0, 0, 0);
        tick(1);
        // R5: zero count with its enable clear
        src_en = 6'h1F;
        zc_pulse = 1'b1;
        chk(1, "R5", 6'h3A, 0, 0, 0);
        tick(1);
        zc_pulse = 1'b0;
        tick(3);
        chk(0, "R5", 6'h1A, 0, 0, 0);
        tick(1);
        src_en = 6'h3F;

        // R9: transmit pending
        tx_empty = 1'b1;
        chk(1, "R9", 6'h1A, 0, 1, 1);
        tick(2);
        rst_tx_cmd = 1'b1;
        chk(1, "R9", 6'h1A, 0, 0, 0);
        tick(1);
        rst_tx_cmd = 1'b0;
        tick(2);
        chk(0, "R9", 6'h1A, 0, 0, 0);
        tick(1);
        tx_eom = 1'b1;
        chk(1, "R9", 6'h1A, 0, 1, 1);
        tick(1);
        tx_eom = 1'b0;
        tick(1);
        rst_tx_cmd = 1'b1; tx_eom = 1'b1;
        chk(1, "R9", 6'h1A, 0, 1, 1);
        tick(1);
        tx_eom = 1'b0;
        chk(1, "R9", 6'h1A, 0, 0, 0);
        tick(1);
        rst_tx_cmd = 1'b0;
        tick(1);
        tx_ie = 1'b0; tx_empty = 1'b0;
        tick(2);
        tx_empty = 1'b1;
        chk(1, "R9", 6'h1A, 0, 0, 0);
        tick(2);
        tx_ie = 1'b1;
        tick(1);

        // R10: polling with master enable off
        mie = 1'b0;
        lines = 5'b11011;
        chk(3, "R10", 6'h1B, 1, 0, 0);
        tick(4);
        mie = 1'b1;
        chk(0, "R10", 6'h1B, 1, 0, 1);
        tick(1);
        rst_ext_cmd = 1'b1;
        chk(1, "R10", 6'h1B, 0, 0, 0);
        tick(1);
        rst_ext_cmd = 1'b0;
        tick(5);
        done = 1'b1;
    end

    initial begin
        int waited;
        waited = 0;
        while (!done && waited < 200000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL queue: actual %0d pending expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule